// File: doc/BRIEF.md
# Cycle-Timed Signed Divider

This block divides a signed 32-bit dividend by a signed 16-bit divisor. It returns one 32-bit word: the 16-bit quotient in the low half and the 16-bit remainder in the high half. The quotient is truncated toward zero, and the remainder takes the sign of the dividend. The block also produces four condition flags (negative, zero, overflow, carry), a divide-by-zero indication and a cycle figure. The cycle figure models the time the operation would take on a microcoded machine. That time depends on the signs of the operands and on the outcome of each trial subtraction.

Internally the block works on magnitudes. A restoring loop produces one quotient bit per clock. After the loop, one fix-up step restores the signs and detects a quotient that does not fit in 16 signed bits. Two cases finish in the cycle after the start instead of running the loop: a zero divisor, and a dividend that is obviously too large for the divisor. A host pulses `start` while `ready` is high and waits for the one-cycle `done` pulse. Every output holds its value until the next completion.

Top module: `sdiv32_cyc`

## Requirements
- R1: The block accepts `start` only while `ready` is high. `done` pulses for one clock. It comes 1 cycle after the start edge for a zero divisor or an early overflow, and 18 cycles after it otherwise. `ready` is high whenever `done` is. `result` changes only in a cycle in which `done` is high.
- R2: When there is no overflow, `result[15:0]` holds the quotient truncated toward zero and `result[31:16]` holds the remainder, which has the sign of the dividend.
- R3: If (|divisor| << 16) <= |dividend|, the operation completes early. `result` equals the dividend, N=1, V=1, Z=0, and the cycle figure is 16.
- R4: If the signed quotient lies outside -32768..32767 and no early overflow applies, `result` equals the dividend, with N=1, V=1 and Z=0.
- R5: Without overflow, V=0, N equals quotient bit 15, and Z=1 exactly when the quotient is zero.
- R6: C is 0 after every operation.
- R7: When the loop runs, the cycle figure is the sum of the following terms:
  - 12 as a base, plus 2 more if the dividend is negative;
  - 6 for each 1 and 8 for each 0 among quotient-magnitude bits 15..1;
  - 4 for bit 0;
  - a closing term of 16 if the divisor is negative, 18 if only the dividend is negative, and 14 otherwise.
- R8: A zero divisor completes without dividing. `div_zero`=1, `result` equals the dividend, N, Z, V and C are all 0, and the cycle figure is 0.
- R9: `div_zero` is 0 from the cycle after any start with a nonzero divisor.
- R10: After reset: `ready`=1, `done`=0, `result`=0, all flags 0, `div_zero`=0 and `cycles`=0.
- R11: A `start` pulse while the block is busy is ignored. It produces no extra completion and does not alter the running result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a division (taken when ready) |
| dividend | input | 32 | Signed dividend |
| divisor | input | 16 | Signed divisor |
| ready | output | 1 | Idle, able to accept start |
| done | output | 1 | One-cycle completion pulse |
| result | output | 32 | {remainder, quotient} or the dividend on overflow / zero divisor |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag, always cleared |
| div_zero | output | 1 | Divisor was zero |
| cycles | output | 8 | Modelled cycle count of the operation |

## Verification
The bound checker watches the relations that must hold at every completion:
- overflow forces N high and Z low;
- a clean result has N and Z matching the returned quotient;
- C stays clear;
- a zero divisor returns the dividend one cycle later with a zero count;
- `result` never moves outside a `done` cycle.

Only the scoreboard scenarios can show the actual quotient and remainder values, the data-dependent cycle sum, and the sign-dependent late overflow cases. The same goes for the completion latency and for a busy-time start being ignored. For these, the bench runs every sign combination, boundary quotients near ±32768, the minimum divisor, and random operands against an arithmetic model.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;

    // modelled cycle charges
    localparam int CYC_BASE        = 12;
    localparam int CYC_NEG_DVD     = 2;
    localparam int CYC_EARLY_OVF   = 16;
    localparam int CYC_BIT_SUB     = 6;
    localparam int CYC_BIT_KEEP    = 8;
    localparam int CYC_BIT_LAST    = 4;
    localparam int CYC_EPI_NEG_DVS = 16;
    localparam int CYC_EPI_NEG_DVD = 18;
    localparam int CYC_EPI_POS     = 14;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FIN
    } div_state_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_flags_t;

    localparam cc_flags_t CC_OVF   = '{n: 1'b1, z: 1'b0, v: 1'b1, c: 1'b0};
    localparam cc_flags_t CC_CLEAR = '{n: 1'b0, z: 1'b0, v: 1'b0, c: 1'b0};

    // charge for one quotient bit step
    function automatic int bit_cost(logic subtracted, logic last_bit);
        if (last_bit)
            return CYC_BIT_LAST;
        return subtracted ? CYC_BIT_SUB : CYC_BIT_KEEP;
    endfunction

endpackage

// File: rtl/sdiv_prep.sv
module sdiv_prep #(
    parameter int DVS_W = 16
) (
    input  logic [2*DVS_W-1:0] dividend,
    input  logic [DVS_W-1:0]   divisor,
    output logic [2*DVS_W-1:0] dvd_mag,
    output logic [2*DVS_W-1:0] dsh_mag,
    output logic               dvd_neg,
    output logic               dvs_neg,
    output logic               dvs_zero,
    output logic               early_ovf
);
    localparam int DVD_W = 2 * DVS_W;

    logic [DVS_W-1:0] dvs_mag;

    always_comb begin
        dvd_neg   = dividend[DVD_W-1];
        dvs_neg   = divisor[DVS_W-1];
        dvs_zero  = (divisor == '0);
        dvd_mag   = dvd_neg ? -dividend : dividend;
        dvs_mag   = dvs_neg ? -divisor : divisor;
        dsh_mag   = {dvs_mag, {DVS_W{1'b0}}};
        early_ovf = !dvs_zero && (dsh_mag <= dvd_mag);
    end
endmodule

// File: rtl/sdiv_step.sv
module sdiv_step #(
    parameter int DVS_W = 16
) (
    input  logic [2*DVS_W-1:0] rem_in,
    input  logic [2*DVS_W-1:0] dsh,
    output logic [2*DVS_W-1:0] rem_out,
    output logic               q_bit
);
    localparam int DVD_W = 2 * DVS_W;

    logic [DVD_W-1:0] shl;

    always_comb begin
        shl     = {rem_in[DVD_W-2:0], 1'b0};
        q_bit   = (shl >= dsh);
        rem_out = q_bit ? (shl - dsh) : shl;
    end
endmodule

// File: rtl/sdiv_fixup.sv
module sdiv_fixup
    import sdiv_pkg::*;
#(
    parameter int DVS_W = 16,
    parameter int CYC_W = 8
) (
    input  logic [DVS_W-1:0]   quo,
    input  logic [2*DVS_W-1:0] rem_word,
    input  logic               dvd_neg,
    input  logic               dvs_neg,
    input  logic [2*DVS_W-1:0] orig,
    output logic [2*DVS_W-1:0] result,
    output cc_flags_t          flags,
    output logic [CYC_W-1:0]   epi_cost
);
    localparam int DVD_W = 2 * DVS_W;
    localparam int MSB   = DVS_W - 1;

    logic [DVS_W-1:0] q_neg, q_fin;
    logic [DVD_W-1:0] r_neg, r_fin;
    logic             ovf;

    always_comb begin
        q_neg = -quo;
        r_neg = -rem_word;
        q_fin = quo;
        r_fin = rem_word;
        ovf   = 1'b0;
        if (dvs_neg) begin
            epi_cost = CYC_W'(CYC_EPI_NEG_DVS);
            if (dvd_neg) begin
                ovf   = quo[MSB];
                r_fin = r_neg;
            end else begin
                q_fin = q_neg;
                ovf   = (q_neg != '0) && !q_neg[MSB];
            end
        end else if (dvd_neg) begin
            epi_cost = CYC_W'(CYC_EPI_NEG_DVD);
            q_fin    = q_neg;
            ovf      = (q_neg != '0) && !q_neg[MSB];
            r_fin    = r_neg;
        end else begin
            epi_cost = CYC_W'(CYC_EPI_POS);
            ovf      = quo[MSB];
        end

        if (ovf) begin
            result = orig;
            flags  = CC_OVF;
        end else begin
            result = {r_fin[DVD_W-1:DVS_W], q_fin};
            flags  = '{n: q_fin[MSB], z: (q_fin == '0), v: 1'b0, c: 1'b0};
        end
    end
endmodule

// File: rtl/sdiv32_cyc.sv
module sdiv32_cyc
    import sdiv_pkg::*;
#(
    parameter int DVS_W = 16,
    parameter int CYC_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [2*DVS_W-1:0]   dividend,
    input  logic [DVS_W-1:0]     divisor,
    output logic                 ready,
    output logic                 done,
    output logic [2*DVS_W-1:0]   result,
    output logic                 flag_n,
    output logic                 flag_z,
    output logic                 flag_v,
    output logic                 flag_c,
    output logic                 div_zero,
    output logic [CYC_W-1:0]     cycles
);
    localparam int DVD_W = 2 * DVS_W;
    localparam int SW    = $clog2(DVS_W);
    localparam logic [SW-1:0] LAST_STEP = SW'(DVS_W - 1);

    div_state_e       state_q;
    logic [DVD_W-1:0] rem_q, dsh_q, orig_q, result_q;
    logic [DVS_W-1:0] quo_q;
    logic [SW-1:0]    step_q;
    logic [CYC_W-1:0] cyc_q, cyc_out_q;
    logic             dvd_neg_q, dvs_neg_q, dz_q, done_q;
    cc_flags_t        flags_q;

    logic [DVD_W-1:0] p_dvd_mag, p_dsh_mag;
    logic             p_dvd_neg, p_dvs_neg, p_dvs_zero, p_early;
    logic [DVD_W-1:0] s_rem;
    logic             s_bit;
    logic [DVD_W-1:0] f_result;
    cc_flags_t        f_flags;
    logic [CYC_W-1:0] f_epi;

    sdiv_prep #(.DVS_W(DVS_W)) u_prep (
        .dividend  (dividend),
        .divisor   (divisor),
        .dvd_mag   (p_dvd_mag),
        .dsh_mag   (p_dsh_mag),
        .dvd_neg   (p_dvd_neg),
        .dvs_neg   (p_dvs_neg),
        .dvs_zero  (p_dvs_zero),
        .early_ovf (p_early)
    );

    sdiv_step #(.DVS_W(DVS_W)) u_step (
        .rem_in  (rem_q),
        .dsh     (dsh_q),
        .rem_out (s_rem),
        .q_bit   (s_bit)
    );

    sdiv_fixup #(.DVS_W(DVS_W), .CYC_W(CYC_W)) u_fix (
        .quo      (quo_q),
        .rem_word (rem_q),
        .dvd_neg  (dvd_neg_q),
        .dvs_neg  (dvs_neg_q),
        .orig     (orig_q),
        .result   (f_result),
        .flags    (f_flags),
        .epi_cost (f_epi)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_IDLE;
            rem_q     <= '0;
            dsh_q     <= '0;
            orig_q    <= '0;
            result_q  <= '0;
            quo_q     <= '0;
            step_q    <= '0;
            cyc_q     <= '0;
            cyc_out_q <= '0;
            dvd_neg_q <= 1'b0;
            dvs_neg_q <= 1'b0;
            dz_q      <= 1'b0;
            done_q    <= 1'b0;
            flags_q   <= CC_CLEAR;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        orig_q    <= dividend;
                        dvd_neg_q <= p_dvd_neg;
                        dvs_neg_q <= p_dvs_neg;
                        dz_q      <= p_dvs_zero;
                        if (p_dvs_zero) begin
                            result_q  <= dividend;
                            flags_q   <= CC_CLEAR;
                            cyc_out_q <= '0;
                            done_q    <= 1'b1;
                        end else if (p_early) begin
                            result_q  <= dividend;
                            flags_q   <= CC_OVF;
                            cyc_out_q <= CYC_W'(CYC_EARLY_OVF);
                            done_q    <= 1'b1;
                        end else begin
                            rem_q   <= p_dvd_mag;
                            dsh_q   <= p_dsh_mag;
                            quo_q   <= '0;
                            step_q  <= '0;
                            cyc_q   <= CYC_W'(CYC_BASE + (p_dvd_neg ? CYC_NEG_DVD : 0));
                            state_q <= ST_RUN;
                        end
                    end
                end
                ST_RUN: begin
                    rem_q  <= s_rem;
                    quo_q  <= {quo_q[DVS_W-2:0], s_bit};
                    cyc_q  <= cyc_q + CYC_W'(bit_cost(s_bit, step_q == LAST_STEP));
                    step_q <= step_q + 1'b1;
                    if (step_q == LAST_STEP)
                        state_q <= ST_FIN;
                end
                ST_FIN: begin
                    result_q  <= f_result;
                    flags_q   <= f_flags;
                    cyc_out_q <= cyc_q + f_epi;
                    done_q    <= 1'b1;
                    state_q   <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign ready    = (state_q == ST_IDLE);
    assign done     = done_q;
    assign result   = result_q;
    assign flag_n   = flags_q.n;
    assign flag_z   = flags_q.z;
    assign flag_v   = flags_q.v;
    assign flag_c   = flags_q.c;
    assign div_zero = dz_q;
    assign cycles   = cyc_out_q;
endmodule

// File: rtl/sdiv32_cyc_chk.sv
module sdiv32_cyc_chk #(
    parameter int DVS_W = 16,
    parameter int CYC_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               start,
    input logic [2*DVS_W-1:0] dividend,
    input logic [DVS_W-1:0]   divisor,
    input logic               ready,
    input logic               done,
    input logic [2*DVS_W-1:0] result,
    input logic               flag_n,
    input logic               flag_z,
    input logic               flag_v,
    input logic               flag_c,
    input logic               div_zero,
    input logic [CYC_W-1:0]   cycles
);
    assert_done_idle_R1: assert property (@(posedge clk) disable iff (rst)
        done |-> ready);

    assert_result_hold_R1: assert property (@(posedge clk) disable iff (rst)
        !done |-> $stable(result));

    assert_ovf_flags_R4: assert property (@(posedge clk) disable iff (rst)
        done && flag_v |-> flag_n && !flag_z);

    assert_clean_flags_R5: assert property (@(posedge clk) disable iff (rst)
        done && !flag_v && !div_zero |->
            (flag_n == result[DVS_W-1]) && (flag_z == (result[DVS_W-1:0] == '0)));

    assert_carry_clear_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> !flag_c);

    assert_zero_div_R8: assert property (@(posedge clk) disable iff (rst)
        start && ready && (divisor == '0) |=>
            done && div_zero && (result == $past(dividend)) && (cycles == '0));

    assert_nz_div_R9: assert property (@(posedge clk) disable iff (rst)
        start && ready && (divisor != '0) |=> !div_zero);
endmodule

bind sdiv32_cyc sdiv32_cyc_chk #(.DVS_W(DVS_W), .CYC_W(CYC_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .dividend (dividend),
    .divisor  (divisor),
    .ready    (ready),
    .done     (done),
    .result   (result),
    .flag_n   (flag_n),
    .flag_z   (flag_z),
    .flag_v   (flag_v),
    .flag_c   (flag_c),
    .div_zero (div_zero),
    .cycles   (cycles)
);

// File: tb/sim_sdiv32_cyc.sv
module sim_sdiv32_cyc;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] dividend = '0;
    logic [15:0] divisor = '0;
    logic        ready, done, flag_n, flag_z, flag_v, flag_c, div_zero;
    logic [31:0] result;
    logic [7:0]  cycles;

    always #5 clk = ~clk;

    sdiv32_cyc u0 (
        .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
        .ready(ready), .done(done), .result(result), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c), .div_zero(div_zero), .cycles(cycles)
    );

    typedef struct {
        logic [31:0] res;
        logic        n, z, v, dz;
        int          cyc;
        int          lat;
        string       res_tag;
        string       cyc_tag;
    } exp_t;

    exp_t   exp_q[$];
    int     n_checks = 0;
    int     n_fail   = 0;
    longint cyc_cnt  = 0;
    longint start_cyc = 0;

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
        end
    endtask

    // arithmetic reference built from the requirements
    function automatic exp_t model(input logic [31:0] dvd, input logic [15:0] dvs);
        exp_t   e;
        longint a, b, am, bm, qm, q, r;
        int     ones;
        a = longint'($signed(dvd));
        b = longint'($signed(dvs));
        e.res = dvd; e.n = 0; e.z = 0; e.v = 0; e.dz = 0;
        e.cyc = 0; e.lat = 1; e.res_tag = "R8"; e.cyc_tag = "R8";
        if (b == 0) begin
            e.dz = 1;
            return e;
        end
        am = (a < 0) ? -a : a;
        bm = (b < 0) ? -b : b;
        if ((bm << 16) <= am) begin
            e.n = 1; e.v = 1; e.cyc = 16; e.res_tag = "R3"; e.cyc_tag = "R3";
            return e;
        end
        qm   = am / bm;
        ones = $countones(qm[15:1]);
        e.lat = 18;
        e.cyc_tag = "R7";
        e.cyc = 12 + ((a < 0) ? 2 : 0) + ones * 6 + (15 - ones) * 8 + 4
              + ((b < 0) ? 16 : ((a < 0) ? 18 : 14));
        q = a / b;
        r = a % b;
        if (q > 32767 || q < -32768) begin
            e.n = 1; e.v = 1; e.res_tag = "R4";
        end else begin
            e.res = {r[15:0], q[15:0]};
            e.n = q[15];
            e.z = (q == 0);
            e.res_tag = "R2";
        end
        return e;
    endfunction

    // monitor / scoreboard
    exp_t m_e;
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R11", "unexpected completion", 1, 0);
            end else begin
                m_e = exp_q.pop_front();
                check(result == m_e.res, m_e.res_tag, "result", result, m_e.res);
                check({flag_n, flag_z, flag_v} == {m_e.n, m_e.z, m_e.v},
                      m_e.v ? m_e.res_tag : (m_e.dz ? "R8" : "R5"), "flags NZV",
                      {flag_n, flag_z, flag_v}, {m_e.n, m_e.z, m_e.v});
                check(flag_c == 1'b0, "R6", "carry flag", flag_c, 0);
                check(div_zero == m_e.dz, m_e.dz ? "R8" : "R9", "div_zero",
                      div_zero, m_e.dz);
                check(int'(cycles) == m_e.cyc, m_e.cyc_tag, "cycle count",
                      cycles, m_e.cyc);
                check((cyc_cnt - start_cyc) == m_e.lat, "R1", "latency",
                      cyc_cnt - start_cyc, m_e.lat);
                check(ready == 1'b1, "R1", "ready at done", ready, 1);
            end
        end
    end

    task automatic launch(input logic [31:0] dvd, input logic [15:0] dvs);
        exp_q.push_back(model(dvd, dvs));
        @(negedge clk);
        dividend  = dvd;
        divisor   = dvs;
        start     = 1'b1;
        start_cyc = cyc_cnt;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_div(input logic [31:0] dvd, input logic [15:0] dvs);
        launch(dvd, dvs);
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", 0, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        exp_t        held;
        logic [31:0] ra;
        logic [15:0] rb;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(ready == 1'b1, "R10", "ready", ready, 1);
        check(done == 1'b0, "R10", "done", done, 0);
        check(result == 32'h0, "R10", "result", result, 0);
        check({flag_n, flag_z, flag_v, flag_c} == 4'b0, "R10", "flags",
              {flag_n, flag_z, flag_v, flag_c}, 0);
        check(div_zero == 1'b0, "R10", "div_zero", div_zero, 0);
        check(cycles == 8'h0, "R10", "cycles", cycles, 0);

        // R2 / R5 / R7 all four sign combinations
        run_div(32'd100, 16'd7);
        run_div(-32'sd100, 16'd7);
        run_div(32'd100, -16'sd7);
        run_div(-32'sd100, -16'sd7);
        run_div(32'd0, 16'd5);               // zero quotient, Z set
        run_div(32'd3, 16'd9);
        run_div(-32'sd3, 16'd9);             // zero quotient from negative dividend
        // R3 early overflow
        run_div(32'h0001_0000, 16'd1);
        run_div(32'h8000_0000, 16'hFFFF);
        run_div(32'h7FFF_FFFF, 16'd2);
        // R4 late overflow and its boundaries
        run_div(32'h0000_8000, 16'd1);       // +32768 overflow
        run_div(-32'sd32768, 16'd1);         // -32768 fits
        run_div(32'h0000_8000, 16'hFFFF);    // -32768 fits
        run_div(-32'sd32768, 16'hFFFF);      // +32768 overflow
        run_div(32'h7FFF_FFFF, 16'h8000);    // -65535 overflow
        run_div(-32'sd65535, 16'h8000);      // +1 with negative remainder
        run_div(32'h0000_7FFF, 16'd1);
        // R8 zero divisor
        run_div(32'h1234_5678, 16'd0);
        run_div(32'hDEAD_BEEF, 16'd0);
        run_div(32'd100, 16'd7);             // R9 clears after zero divisor

        // R11 start while busy is ignored
        held = model(32'd1000, 16'd33);
        launch(32'd1000, 16'd33);
        repeat (4) @(negedge clk);
        dividend = 32'd5;
        divisor  = 16'd0;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        repeat (25) @(negedge clk);
        check(result == held.res, "R11", "result after busy start", result, held.res);
        check(div_zero == 1'b0, "R11", "div_zero after busy start", div_zero, 0);

        // random mix
        for (int i = 0; i < 60; i++) begin
            ra = $urandom;
            ra = 32'($signed(ra) >>> (i % 24));
            rb = 16'($urandom);
            if (i % 5 == 0) rb = 16'($signed(rb) >>> 8);
            run_div(ra, rb);
        end

        repeat (5) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule